// File: doc/BRIEF.md
# Spread-spectrum modulation profile generator

This block runs on the reference clock and produces a signed frequency-offset word. A downstream fractional divider or numerically controlled oscillator adds the word to its nominal setting. The offset follows a triangle that is centred on zero, so the synthesized clock sweeps equally above and below its nominal frequency. Spreading the clock energy this way lowers the peak of its emission spectrum. One offset unit stands for 0.05 % of the nominal frequency.

Two select inputs are each coded as low, middle or high. Together they pick one of nine spread settings. Five of these are wide settings meant for slow reference clocks, and four are narrow settings meant for fast ones. A band input picks the row of the depth table that matches the reference frequency range. An enable input starts the sweep, or parks it at zero offset. The enable input should be tied high through a pull-up at integration, so that an undriven input keeps the modulation active. Whatever the setting, one modulation cycle always takes a fixed number of reference cycles.

Top module: `sscg_profile_gen`

## Requirements
- R1: Each 2-bit select code is decoded as 2'b00 low, 2'b01 middle and 2'b10 high. The spare code 2'b11 behaves exactly like middle.
- R2: The wide settings, given as (sel1,sel0), take peak depths in offset units for band rows 0 to 4. (M,M) gives 38/35/32/30/28. (M,L) gives 32/30/28/26/24. (H,L) gives 28/25/24/22/20. (L,L) gives 23/21/19/18/17. (L,M) gives 19/17/16/15/14.
- R3: The narrow settings take peak depths for band rows 0 to 4. (H,M) gives 25/24/23/20/18. (L,H) gives 19/18/16/14/13. (H,H) gives 12/11/11/10/8. (M,H) gives 10/9/9/8/6.
- R4: Band codes 0 to 4 select depth-table rows 0 to 4. Band codes 5, 6 and 7 use row 4.
- R5: An internal phase p runs from 0 to 1165 and wraps, so one sweep lasts exactly 1166 clocks. With depth D, offset = sign(u)·floor(D·|u|/583). Here u = 2p−583 for p ≤ 583 and u = 1749−2p otherwise.
- R6: The offset stays within ±D. It reaches +D exactly at the sweep maximum (p = 583) and −D exactly at the minimum (p = 0).
- R7: A clock edge with enable low makes the offset 0 and parks p at the centre value 292. The first enabled edge after that moves p to 293, so the sweep resumes from zero offset going upward.
- R8: The depth is taken from the selects and band at only two points: the first enabled edge after reset or disable, and the edge where p wraps from 1165 to 0. Select or band changes at any other time have no effect on the offset.
- R9: An active-low reset clears the block asynchronously and gives offset 0. After the reset input rises, the block stays in reset for two more rising clock edges.
- R10: Within a sweep, two consecutive offsets never differ by more than one unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Modulation enable; low parks the offset at zero |
| sel1_i | input | 2 | First three-level spread select |
| sel0_i | input | 2 | Second three-level spread select |
| band_i | input | BAND_W (3) | Reference frequency band, picks the depth row |
| offset_o | output | OFS_W (8) | Signed frequency offset in 0.05 % units |

## Verification
The bench builds the block with its default parameters: a half-sweep of 583, a 3-bit band input and an 8-bit offset. With these values the exact 1166-clock sweep is observed. The band input can reach codes 5 to 7, which lie past the last table row. The reciprocal scaler is exercised at its widest multiplier and at the deepest entry of 38, where its rounding margin is smallest. Every select code pair, including the spare code, is swept against every band code, and the peak reached is compared with the table. Select changes made in the middle of a sweep, disable and re-enable, and an asynchronous reset during a sweep are each followed against a cycle-accurate model.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

  // Decoded level of one three-state select input
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;

  localparam int DEPTH_W  = 6;
  localparam int ROWS     = 5;
  localparam int WIDE_N   = 5;
  localparam int NARROW_N = 4;
  localparam int ROW_IW   = $clog2(ROWS);
  localparam int COL_IW   = $clog2(WIDE_N);

  typedef logic [DEPTH_W-1:0] depth_t;

  // Peak depth in 0.05 % units, [band row][wide column]
  localparam depth_t WIDE_TBL [ROWS][WIDE_N] = '{
    '{6'd38, 6'd32, 6'd28, 6'd23, 6'd19},
    '{6'd35, 6'd30, 6'd25, 6'd21, 6'd17},
    '{6'd32, 6'd28, 6'd24, 6'd19, 6'd16},
    '{6'd30, 6'd26, 6'd22, 6'd18, 6'd15},
    '{6'd28, 6'd24, 6'd20, 6'd17, 6'd14}
  };

  // Peak depth in 0.05 % units, [band row][narrow column]
  localparam depth_t NARROW_TBL [ROWS][NARROW_N] = '{
    '{6'd25, 6'd19, 6'd12, 6'd10},
    '{6'd24, 6'd18, 6'd11, 6'd9},
    '{6'd23, 6'd16, 6'd11, 6'd9},
    '{6'd20, 6'd14, 6'd10, 6'd8},
    '{6'd18, 6'd13, 6'd8,  6'd6}
  };

endpackage

// File: rtl/sscg_level_dec.sv
module sscg_level_dec
  import sscg_pkg::*;
(
  input  logic [1:0] code_i,
  output lvl_e       lvl_o
);

  // R1: spare code 2'b11 folds onto middle
  always_comb begin
    case (code_i)
      2'b00:   lvl_o = LVL_LOW;
      2'b10:   lvl_o = LVL_HIGH;
      default: lvl_o = LVL_MID;
    endcase
  end

endmodule

// File: rtl/sscg_depth_lut.sv
module sscg_depth_lut
  import sscg_pkg::*;
#(
  parameter int BAND_W = 3
) (
  input  lvl_e              s1_i,
  input  lvl_e              s0_i,
  input  logic [BAND_W-1:0] band_i,
  output depth_t            depth_o
);

  logic [ROW_IW-1:0] row;
  logic [COL_IW-1:0] col;
  logic              wide;

  // R4: rows past the table reuse the last row
  always_comb begin
    if (band_i > BAND_W'(ROWS - 1)) row = ROW_IW'(ROWS - 1);
    else                            row = ROW_IW'(band_i);
  end

  // R2/R3: map the select pair onto a table column
  always_comb begin
    wide = 1'b1;
    col  = '0;
    case ({s1_i, s0_i})
      {LVL_MID,  LVL_MID }: col = COL_IW'(0);
      {LVL_MID,  LVL_LOW }: col = COL_IW'(1);
      {LVL_HIGH, LVL_LOW }: col = COL_IW'(2);
      {LVL_LOW,  LVL_LOW }: col = COL_IW'(3);
      {LVL_LOW,  LVL_MID }: col = COL_IW'(4);
      {LVL_HIGH, LVL_MID }: begin wide = 1'b0; col = COL_IW'(0); end
      {LVL_LOW,  LVL_HIGH}: begin wide = 1'b0; col = COL_IW'(1); end
      {LVL_HIGH, LVL_HIGH}: begin wide = 1'b0; col = COL_IW'(2); end
      {LVL_MID,  LVL_HIGH}: begin wide = 1'b0; col = COL_IW'(3); end
      default:              col = '0;
    endcase
  end

  assign depth_o = wide ? WIDE_TBL[row][col] : NARROW_TBL[row][col[1:0]];

endmodule

// File: rtl/sscg_sweep.sv
module sscg_sweep
  import sscg_pkg::*;
#(
  parameter  int HALF_LEN = 583,
  parameter  int OFS_W    = 8,
  localparam int PH_W     = $clog2(2 * HALF_LEN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  depth_t                  depth_i,
  output logic [PH_W-1:0]         phase_o,
  output depth_t                  depth_o,
  output logic signed [OFS_W-1:0] offset_o
);

  localparam int PERIOD = 2 * HALF_LEN;
  localparam int LAST   = PERIOD - 1;
  localparam int CENTRE = HALF_LEN / 2 + 1;
  localparam int SHIFT  = 24;
  localparam int RECIP  = ((1 << SHIFT) + HALF_LEN - 1) / HALF_LEN;
  localparam int PROD_W = DEPTH_W + PH_W + SHIFT + 1;

  logic [PH_W-1:0]         phase_q, phase_d;
  depth_t                  depth_q, depth_d;
  logic                    live_q, live_d;
  logic signed [OFS_W-1:0] ofs_q, ofs_d;
  logic                    wrap, depth_ld;

  int                      tri_u;
  logic                    neg;
  logic [PH_W-1:0]         umag;
  logic [PROD_W-1:0]       prod;
  depth_t                  scaled;

  // Next state: phase, load enable for depth, running flag
  always_comb begin
    wrap     = (phase_q == PH_W'(LAST));
    depth_ld = en_i && (!live_q || wrap);
    depth_d  = depth_ld ? depth_i : depth_q;
    live_d   = en_i;
    if (!en_i)     phase_d = PH_W'(CENTRE);
    else if (wrap) phase_d = '0;
    else           phase_d = phase_q + PH_W'(1);
  end

  // Triangle position of the next phase and its scaled magnitude
  always_comb begin
    if (int'(phase_d) <= HALF_LEN) tri_u = 2 * int'(phase_d) - HALF_LEN;
    else                           tri_u = 3 * HALF_LEN - 2 * int'(phase_d);
    neg    = (tri_u < 0);
    umag   = PH_W'(neg ? -tri_u : tri_u);
    prod   = PROD_W'(depth_d) * PROD_W'(umag) * PROD_W'(RECIP);
    scaled = prod[SHIFT +: DEPTH_W];
    ofs_d  = neg ? -OFS_W'(scaled) : OFS_W'(scaled);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_W'(CENTRE);
      depth_q <= '0;
      live_q  <= 1'b0;
      ofs_q   <= '0;
    end else begin
      phase_q <= phase_d;
      live_q  <= live_d;
      ofs_q   <= ofs_d;
      if (depth_ld) depth_q <= depth_i;
    end
  end

  assign phase_o  = phase_q;
  assign depth_o  = depth_q;
  assign offset_o = ofs_q;

endmodule

// File: rtl/sscg_rst_sync.sv
module sscg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sr_q[STAGES-1];

endmodule

// File: rtl/sscg_profile_gen.sv
module sscg_profile_gen
  import sscg_pkg::*;
#(
  parameter int HALF_LEN = 583,
  parameter int BAND_W   = 3,
  parameter int OFS_W    = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [1:0]              sel1_i,
  input  logic [1:0]              sel0_i,
  input  logic [BAND_W-1:0]       band_i,
  output logic signed [OFS_W-1:0] offset_o
);

  localparam int PH_W = $clog2(2 * HALF_LEN);

  logic            rst_sync_n;
  logic [1:0]      sel_code [2];
  lvl_e            sel_lvl  [2];
  depth_t          depth_sel;
  logic [PH_W-1:0] sweep_phase;
  depth_t          sweep_depth;

  assign sel_code[0] = sel0_i;
  assign sel_code[1] = sel1_i;

  sscg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  for (genvar g = 0; g < 2; g++) begin : g_dec
    sscg_level_dec u_dec (
      .code_i (sel_code[g]),
      .lvl_o  (sel_lvl[g])
    );
  end

  sscg_depth_lut #(.BAND_W(BAND_W)) u_lut (
    .s1_i    (sel_lvl[1]),
    .s0_i    (sel_lvl[0]),
    .band_i  (band_i),
    .depth_o (depth_sel)
  );

  sscg_sweep #(.HALF_LEN(HALF_LEN), .OFS_W(OFS_W)) u_sweep (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .en_i     (en_i),
    .depth_i  (depth_sel),
    .phase_o  (sweep_phase),
    .depth_o  (sweep_depth),
    .offset_o (offset_o)
  );

endmodule

// File: rtl/sscg_profile_chk.sv
module sscg_profile_chk
  import sscg_pkg::*;
#(
  parameter  int HALF_LEN = 583,
  parameter  int OFS_W    = 8,
  localparam int PH_W     = $clog2(2 * HALF_LEN)
) (
  input logic                    clk_i,
  input logic                    rst_n,
  input logic                    en_i,
  input logic [PH_W-1:0]         phase,
  input depth_t                  depth,
  input logic signed [OFS_W-1:0] offset
);

  localparam int CENTRE = HALF_LEN / 2 + 1;

  a_r7_off_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> offset == '0);

  a_r6_peak: assert property (@(posedge clk_i) disable iff (!rst_n)
    phase == PH_W'(HALF_LEN) |-> int'(offset) == int'(depth));

  a_r6_trough: assert property (@(posedge clk_i) disable iff (!rst_n)
    phase == '0 |-> int'(offset) == -int'(depth));

  a_r6_bound: assert property (@(posedge clk_i) disable iff (!rst_n)
    (int'(offset) <= int'(depth)) && (int'(offset) >= -int'(depth)));

  a_r8_depth_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(depth) |-> (phase == '0 || phase == PH_W'(CENTRE + 1)));

  a_r10_step: assert property (@(posedge clk_i) disable iff (!rst_n)
    (phase != '0 && phase != PH_W'(CENTRE)) |->
      ((int'(offset) - int'($past(offset)) <= 1) &&
       (int'(offset) - int'($past(offset)) >= -1)));

endmodule

bind sscg_profile_gen sscg_profile_chk #(.HALF_LEN(HALF_LEN), .OFS_W(OFS_W)) u_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_sync_n),
  .en_i   (en_i),
  .phase  (sweep_phase),
  .depth  (sweep_depth),
  .offset (offset_o)
);

// File: tb/test_sscg_profile_gen.sv
module test_sscg_profile_gen;

  localparam int HALF = 583;
  localparam int PER  = 2 * HALF;
  localparam int CEN  = HALF / 2 + 1;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              en;
  logic [1:0]        s1, s0;
  logic [2:0]        band;
  logic signed [7:0] offset;

  int n_chk = 0, n_fail = 0, n_tick = 0;
  int m_phase, m_depth, m_live, m_sync;
  int pk_max, pk_min, step_max, prev_o, t_first, t_second;
  bit done = 0;

  int wide_t [5][5] = '{'{38,32,28,23,19}, '{35,30,25,21,17}, '{32,28,24,19,16},
                        '{30,26,22,18,15}, '{28,24,20,17,14}};
  int narrow_t [5][4] = '{'{25,19,12,10}, '{24,18,11,9}, '{23,16,11,9},
                          '{20,14,10,8}, '{18,13,8,6}};

  always #10 clk = ~clk;

  sscg_profile_gen i_sscg_profile_gen (
    .clk_i (clk), .rst_ni (rst_ni), .en_i (en),
    .sel1_i (s1), .sel0_i (s0), .band_i (band), .offset_o (offset)
  );

  function automatic int lvl(int code);
    return (code == 0) ? 0 : (code == 2) ? 2 : 1;
  endfunction

  // key = level1*3 + level0, with 0 low, 1 middle, 2 high
  function automatic bit is_wide(int c1, int c0);
    int k = lvl(c1) * 3 + lvl(c0);
    return (k == 4 || k == 3 || k == 6 || k == 0 || k == 1);
  endfunction

  function automatic int depth_of(int c1, int c0, int b);
    int row = (b > 4) ? 4 : b;
    case (lvl(c1) * 3 + lvl(c0))
      4: return wide_t[row][0];
      3: return wide_t[row][1];
      6: return wide_t[row][2];
      0: return wide_t[row][3];
      1: return wide_t[row][4];
      7: return narrow_t[row][0];
      2: return narrow_t[row][1];
      8: return narrow_t[row][2];
      default: return narrow_t[row][3];
    endcase
  endfunction

  function automatic int shape(int d, int p);
    int u = (p <= HALF) ? 2 * p - HALF : 3 * HALF - 2 * p;
    int m = (d * ((u < 0) ? -u : u)) / HALF;
    return (u < 0) ? -m : m;
  endfunction

  task automatic model_reset();
    m_phase = CEN; m_depth = 0; m_live = 0; m_sync = 0;
  endtask

  task automatic model_edge();
    bit wrap;
    if (!rst_ni) model_reset();
    else if (m_sync < 2) m_sync++;
    else begin
      wrap = (m_phase == PER - 1);
      if (!en) begin
        m_phase = CEN; m_live = 0;
      end else begin
        if (!m_live || wrap) m_depth = depth_of(int'(s1), int'(s0), int'(band));
        m_phase = wrap ? 0 : m_phase + 1;
        m_live  = 1;
      end
    end
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic tick(string tag);
    int o, d;
    @(posedge clk); #1;
    n_tick++;
    model_edge();
    o = int'(offset);
    check(tag, o, shape(m_depth, m_phase));
    if (o > pk_max) pk_max = o;
    if (o < pk_min) pk_min = o;
    d = (o > prev_o) ? o - prev_o : prev_o - o;
    if (d > step_max) step_max = d;
    prev_o = o;
  endtask

  task automatic clear_stats();
    pk_max = -1000; pk_min = 1000; step_max = 0; prev_o = int'(offset);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog: actual %0d cycles expected completion", 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    string tag;
    rst_ni = 1'b0; en = 1'b1; s1 = 2'b01; s0 = 2'b01; band = 3'd0;
    model_reset();
    clear_stats();
    #1;
    check("R9", int'(offset), 0);
    repeat (3) tick("R9");
    rst_ni = 1'b1;
    repeat (2) tick("R9");

    // Full sweeps at the deepest setting
    clear_stats();
    t_first = -1; t_second = -1;
    for (int i = 0; i < 2 * PER; i++) begin
      tick("R5");
      if (int'(offset) == -38) begin
        if (t_first < 0) t_first = n_tick; else if (t_second < 0) t_second = n_tick;
      end
    end
    check("R6", pk_max, 38);
    check("R6", pk_min, -38);
    check("R5", t_second - t_first, PER);
    check("R10", step_max, 1);

    // Mid-sweep select change waits for the wrap
    s1 = 2'b00; s0 = 2'b01; band = 3'd4;
    clear_stats();
    repeat (600) tick("R8");
    check("R8", pk_max, 38);
    clear_stats();
    repeat (900) tick("R8");
    check("R8", pk_max, 14);

    // Disable parks at zero, re-enable resumes from centre with fresh depth
    en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick("R7");
      check("R7", int'(offset), 0);
    end
    s1 = 2'b01; s0 = 2'b01; band = 3'd0;
    en = 1'b1;
    tick("R7");
    check("R7", int'(offset), 0);
    repeat (HALF - CEN - 1) tick("R7");
    check("R7", int'(offset), 38);

    // Every select code pair against every band code
    for (int c1 = 0; c1 < 4; c1++) begin
      for (int c0 = 0; c0 < 4; c0++) begin
        for (int b = 0; b < 8; b++) begin
          if (c1 == 3 || c0 == 3) tag = "R1";
          else if (b > 4)         tag = "R4";
          else if (is_wide(c1, c0)) tag = "R2";
          else                    tag = "R3";
          en = 1'b0;
          tick("R7");
          s1 = 2'(c1); s0 = 2'(c0); band = 3'(b);
          en = 1'b1;
          clear_stats();
          repeat (300) tick(tag);
          check(tag, pk_max, depth_of(c1, c0, b));
        end
      end
    end

    // Asynchronous reset in the middle of a sweep
    s1 = 2'b01; s0 = 2'b01; band = 3'd0;
    repeat (100) tick("R5");
    rst_ni = 1'b0;
    model_reset();
    #1;
    check("R9", int'(offset), 0);
    repeat (2) tick("R9");
    rst_ni = 1'b1;
    repeat (2) tick("R9");
    repeat (400) tick("R5");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule